// File: doc/BRIEF.md
# Asynchronous Host Write Port

This block is the write side of a slave interface on an asynchronous parallel host bus. The host drives an active-low chip select, an active-low write strobe, a 7-bit word address that stands for address lines 7 down to 1, and a 32-bit data bus. A width input puts the port in a 16-bit mode, in which only the low half of the data bus carries data. The port samples the strobes in a local clock domain and finds where each write cycle ends. At that point it issues exactly one action: a register write, a half-word store, or a push into the transmit data FIFO.

A FIFO-select input, which has the same timing as the address lines, bypasses address decoding. While it is high, every write goes to the transmit FIFO, whatever the upper address bits are. A host that must increment its address on each access can therefore stream data into the FIFO. In 16-bit mode the port assembles each 32-bit FIFO word from two half-word writes. A full FIFO causes the write to be dropped and sets a sticky overrun flag.

Top module: `hostWritePort`

## Requirements
- R1: While `rstN` is low and right after reset, `regWrEn`, `fifoWrEn` and `overrun` are 0, and `regIdx`, `regData` and `fifoData` are zero. A reset clears an `overrun` that was set before it.
- R2: A write cycle exists only while `csN` and `wrN` are both low. If only one of the two strobes is low, however long, the port produces no register write and no FIFO write.
- R3: The strobes may assert in either order and may deassert in either order. The cycle ends at the first deassertion. Each cycle gives exactly one output action, which comes as a single-cycle pulse no more than 6 clock cycles after the ending deassertion.
- R4: The port acts on the address, data and FIFO-select values present just before the cycle ends. Values driven earlier in the cycle are overwritten. Values driven from the ending deassertion onward have no effect.
- R5: When `fifoSel` is 0 in 32-bit mode (`mode16`=0), the port pulses `regWrEn` with `regIdx` equal to `addrBus` and `regData` equal to `dataBus`.
- R6: When `fifoSel` is 0 in 16-bit mode (`mode16`=1), `regData` is `{16'h0000, dataBus[15:0]}`, and bits 31:16 of the data bus are ignored.
- R7: When `fifoSel` is 1, `regWrEn` stays 0 and the write goes to the FIFO path. `addrBus[6:1]` (address lines 7 to 2) has no effect on the result.
- R8: When `fifoSel` is 1 in 32-bit mode, each write pulses `fifoWrEn` with `fifoData` equal to `dataBus`, whatever the value of `addrBus[0]`.
- R9: When `fifoSel` is 1 in 16-bit mode, `addrBus[0]` (address line 1) selects the half. A 0 stores `dataBus[15:0]` as the low half and produces no pulse. A 1 pulses `fifoWrEn` with `fifoData = {dataBus[15:0], stored low half}`.
- R10: If a FIFO push would happen while `fifoFull` is 1, the push is dropped and `overrun` goes to 1. `overrun` then stays 1 until reset. Register writes are not affected by `fifoFull`.
- R11: `regWrEn` and `fifoWrEn` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Host chip select, active low, asynchronous |
| wrN | input | 1 | Host write strobe, active low, asynchronous |
| addrBus | input | 7 | Host word address (address lines 7..1) |
| dataBus | input | 32 | Host write data |
| fifoSel | input | 1 | Sends every write to the transmit FIFO |
| mode16 | input | 1 | 1 selects 16-bit bus mode (static while idle) |
| fifoFull | input | 1 | Transmit FIFO cannot accept a word |
| regWrEn | output | 1 | Single-cycle register write strobe |
| regIdx | output | 7 | Register word index |
| regData | output | 32 | Register write data |
| fifoWrEn | output | 1 | Single-cycle FIFO push strobe |
| fifoData | output | 32 | FIFO push word |
| overrun | output | 1 | Sticky flag for a dropped FIFO push |

## Verification
The strobe synchronizer and the aligned address/data pipeline are the parts most likely to hold a wrong internal state. A pipeline that is misaligned or lags by one stage shows up at the first write as wrong data or a wrong index. The bench catches this because it changes the data partway through every cycle and again at the ending edge. A bad end-of-cycle detector shows up within a few clocks as a missing pulse, a doubled pulse, or a pulse caused by a lone strobe. A corrupted stored low half shows up only at the next high-half push in 16-bit mode.

// File: rtl/hpw_pkg.sv
package hpw_pkg;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic capture;  // latch the aligned bus sample into the shadow registers
    logic regWr;    // issue a register write from the shadow
    logic holdLow;  // keep the low half-word for later assembly
    logic push;     // push a word into the FIFO
    logic drop;     // a push was refused because the FIFO is full
  } ctlStrobes_t;

endpackage

// File: rtl/hpw_control.sv
module hpw_control
  import hpw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        wrN,
  input  logic        mode16,
  input  logic        fifoFull,
  input  logic        shFifoSel,
  input  logic        shHalfHi,
  output ctlStrobes_t ctl
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] csSync;
  logic [LAST:0] wrSync;
  logic          activeNow;
  logic          activeQ;
  logic          endPulse;

  generate
    if (SYNC_STAGES == 1) begin : gSingle
      always_ff @(posedge clk) begin
        if (!rstN) begin
          csSync <= '1;
          wrSync <= '1;
        end else begin
          csSync <= csN;
          wrSync <= wrN;
        end
      end
    end else begin : gChain
      always_ff @(posedge clk) begin
        if (!rstN) begin
          csSync <= '1;
          wrSync <= '1;
        end else begin
          csSync <= {csSync[LAST-1:0], csN};
          wrSync <= {wrSync[LAST-1:0], wrN};
        end
      end
    end
  endgenerate

  assign activeNow = ~csSync[LAST] & ~wrSync[LAST];

  always_ff @(posedge clk) begin
    if (!rstN) activeQ <= 1'b0;
    else       activeQ <= activeNow;
  end

  assign endPulse = activeQ & ~activeNow;

  always_comb begin
    ctl         = '0;
    ctl.capture = activeNow;
    if (endPulse) begin
      if (!shFifoSel) begin
        ctl.regWr = 1'b1;
      end else if (mode16 && !shHalfHi) begin
        ctl.holdLow = 1'b1;
      end else if (fifoFull) begin
        ctl.drop = 1'b1;
      end else begin
        ctl.push = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hpw_datapath.sv
module hpw_datapath
  import hpw_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              fifoSelIn,
  input  logic              mode16,
  input  ctlStrobes_t       ctl,
  output logic              shFifoSel,
  output logic              shHalfHi,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regIdx,
  output logic [DATA_W-1:0] regData,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoData,
  output logic              overrun
);

  localparam int HALF_W = DATA_W / 2;
  localparam int PIPE_W = 1 + ADDR_W + DATA_W;

  // Bus sample delayed by the same depth as the strobe synchronizer.
  logic [PIPE_W-1:0] pipeQ [SYNC_STAGES];
  logic [ADDR_W-1:0] shAddr;
  logic [DATA_W-1:0] shData;
  logic [HALF_W-1:0] lowHalf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) pipeQ[i] <= '0;
    end else begin
      pipeQ[0] <= {fifoSelIn, addrIn, dataIn};
      for (int i = 1; i < SYNC_STAGES; i++) pipeQ[i] <= pipeQ[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shFifoSel <= 1'b0;
      shAddr    <= '0;
      shData    <= '0;
    end else if (ctl.capture) begin
      {shFifoSel, shAddr, shData} <= pipeQ[SYNC_STAGES-1];
    end
  end

  assign shHalfHi = shAddr[0];

  always_ff @(posedge clk) begin
    if (!rstN)            lowHalf <= '0;
    else if (ctl.holdLow) lowHalf <= shData[HALF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWrEn  <= 1'b0;
      regIdx   <= '0;
      regData  <= '0;
      fifoWrEn <= 1'b0;
      fifoData <= '0;
      overrun  <= 1'b0;
    end else begin
      regWrEn  <= ctl.regWr;
      fifoWrEn <= ctl.push;
      overrun  <= overrun | ctl.drop;
      if (ctl.regWr) begin
        regIdx  <= shAddr;
        regData <= mode16 ? {{HALF_W{1'b0}}, shData[HALF_W-1:0]} : shData;
      end
      if (ctl.push) begin
        fifoData <= mode16 ? {shData[HALF_W-1:0], lowHalf} : shData;
      end
    end
  end

endmodule

// File: rtl/hostWritePort.sv
module hostWritePort
  import hpw_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addrBus,
  input  logic [DATA_W-1:0] dataBus,
  input  logic              fifoSel,
  input  logic              mode16,
  input  logic              fifoFull,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regIdx,
  output logic [DATA_W-1:0] regData,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoData,
  output logic              overrun
);

  ctlStrobes_t ctl;
  logic        shFifoSel;
  logic        shHalfHi;

  hpw_control #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .wrN       (wrN),
    .mode16    (mode16),
    .fifoFull  (fifoFull),
    .shFifoSel (shFifoSel),
    .shHalfHi  (shHalfHi),
    .ctl       (ctl)
  );

  hpw_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .addrIn    (addrBus),
    .dataIn    (dataBus),
    .fifoSelIn (fifoSel),
    .mode16    (mode16),
    .ctl       (ctl),
    .shFifoSel (shFifoSel),
    .shHalfHi  (shHalfHi),
    .regWrEn   (regWrEn),
    .regIdx    (regIdx),
    .regData   (regData),
    .fifoWrEn  (fifoWrEn),
    .fifoData  (fifoData),
    .overrun   (overrun)
  );

endmodule

// File: rtl/hpw_checker.sv
module hpw_checker (
  input logic clk,
  input logic rstN,
  input logic fifoFull,
  input logic regWrEn,
  input logic fifoWrEn,
  input logic overrun
);

  // R11
  onehot_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrEn, fifoWrEn}));

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R10
  push_not_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> !$past(fifoFull));

  // R10
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(fifoFull));

  // R3
  reg_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R3
  fifo_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |=> !fifoWrEn);

endmodule

bind hostWritePort hpw_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .fifoFull (fifoFull),
  .regWrEn  (regWrEn),
  .fifoWrEn (fifoWrEn),
  .overrun  (overrun)
);

// File: tb/sim_hostWritePort.sv
module sim_hostWritePort;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        wrN = 1'b1;
  logic [6:0]  addrBus = '0;
  logic [31:0] dataBus = '0;
  logic        fifoSel = 1'b0;
  logic        mode16 = 1'b0;
  logic        fifoFull = 1'b0;
  logic        regWrEn;
  logic [6:0]  regIdx;
  logic [31:0] regData;
  logic        fifoWrEn;
  logic [31:0] fifoData;
  logic        overrun;

  always #2.5 clk = ~clk;

  hostWritePort u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN),
    .addrBus(addrBus), .dataBus(dataBus), .fifoSel(fifoSel),
    .mode16(mode16), .fifoFull(fifoFull),
    .regWrEn(regWrEn), .regIdx(regIdx), .regData(regData),
    .fifoWrEn(fifoWrEn), .fifoData(fifoData), .overrun(overrun)
  );

  typedef struct {
    bit          isFifo;
    logic [6:0]  idx;
    logic [31:0] data;
    string       tag;
  } evt_t;

  evt_t        expQ[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [15:0] modelLow = '0;
  bit          modelOverrun = 1'b0;

  // Compare every output pulse with the reference queue.
  always @(negedge clk) begin
    if (rstN) begin
      if (regWrEn && fifoWrEn) begin
        checks++; errors++;
        $display("FAIL R11: both strobes high, actual reg=1 fifo=1 expected one at most");
      end
      if (regWrEn || fifoWrEn) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected pulse reg=%0b fifo=%0b data=%h, expected none",
                   regWrEn, fifoWrEn, regWrEn ? regData : fifoData);
        end else begin
          evt_t e;
          e = expQ.pop_front();
          if (e.isFifo) begin
            if (!fifoWrEn || fifoData !== e.data) begin
              errors++;
              $display("FAIL %s: fifo pulse=%0b data=%h, expected pulse=1 data=%h",
                       e.tag, fifoWrEn, fifoData, e.data);
            end
          end else begin
            if (!regWrEn || regIdx !== e.idx || regData !== e.data) begin
              errors++;
              $display("FAIL %s: reg pulse=%0b idx=%h data=%h, expected pulse=1 idx=%h data=%h",
                       e.tag, regWrEn, regIdx, regData, e.idx, e.data);
            end
          end
        end
      end
    end
  end

  task automatic expectEmpty(input string tag);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d expected actions missing, expected 0", tag, expQ.size());
      expQ.delete();
    end
  endtask

  task automatic checkOverrun(input string tag);
    checks++;
    if (overrun !== modelOverrun) begin
      errors++;
      $display("FAIL %s: overrun=%0b expected %0b", tag, overrun, modelOverrun);
    end
  endtask

  // Reference model: decide the expected action from the requirements.
  task automatic model(input logic [6:0] a, input logic [31:0] d, input logic fs);
    evt_t e;
    if (!fs) begin
      e.isFifo = 1'b0; e.idx = a;
      e.data = mode16 ? {16'h0000, d[15:0]} : d;
      e.tag = mode16 ? "R6" : "R5";
      expQ.push_back(e);
    end else if (mode16 && !a[0]) begin
      modelLow = d[15:0];
    end else if (fifoFull) begin
      modelOverrun = 1'b1;
    end else begin
      e.isFifo = 1'b1; e.idx = '0;
      e.data = mode16 ? {d[15:0], modelLow} : d;
      e.tag = mode16 ? "R9" : "R8";
      expQ.push_back(e);
    end
  endtask

  // One host write: early data is a decoy (R4), wrFirst picks the order (R3).
  task automatic hostWrite(input logic [6:0] a, input logic [31:0] d,
                           input logic fs, input bit wrFirst);
    addrBus = ~a; dataBus = ~d; fifoSel = fs;
    @(negedge clk);
    if (wrFirst) wrN = 1'b0; else csN = 1'b0;
    @(negedge clk);
    if (wrFirst) csN = 1'b0; else wrN = 1'b0;
    repeat (2) @(negedge clk);
    addrBus = a; dataBus = d;
    repeat (3) @(negedge clk);
    model(a, d, fs);
    if (wrFirst) wrN = 1'b1; else csN = 1'b1;
    addrBus = ~a; dataBus = ~d; fifoSel = ~fs;
    @(negedge clk);
    if (wrFirst) csN = 1'b1; else wrN = 1'b1;
    repeat (6) @(negedge clk);
    expectEmpty("R3");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (regWrEn !== 1'b0 || fifoWrEn !== 1'b0 || overrun !== 1'b0 ||
        regIdx !== '0 || regData !== '0 || fifoData !== '0) begin
      errors++;
      $display("FAIL R1: reg=%0b fifo=%0b ovr=%0b idx=%h rd=%h fd=%h expected all zero",
               regWrEn, fifoWrEn, overrun, regIdx, regData, fifoData);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R5 register writes, both strobe orders (R3, R4)
    hostWrite(7'h15, 32'hDEADBEEF, 1'b0, 1'b1);
    hostWrite(7'h6A, 32'h01234567, 1'b0, 1'b0);

    // R2 a lone strobe does nothing
    csN = 1'b0; repeat (8) @(negedge clk); csN = 1'b1;
    repeat (4) @(negedge clk);
    wrN = 1'b0; repeat (8) @(negedge clk); wrN = 1'b1;
    repeat (6) @(negedge clk);
    expectEmpty("R2");

    // R7, R8 FIFO writes, upper address ignored
    hostWrite(7'h7C, 32'hCAFEF00D, 1'b1, 1'b0);
    hostWrite(7'h03, 32'h13579BDF, 1'b1, 1'b1);
    hostWrite(7'h00, 32'h2468ACE0, 1'b1, 1'b0);
    checkOverrun("R10");

    // R10 full FIFO drops the push; register path unaffected
    fifoFull = 1'b1;
    hostWrite(7'h41, 32'hBAD0BAD0, 1'b1, 1'b1);
    hostWrite(7'h22, 32'h55AA55AA, 1'b0, 1'b0);
    checkOverrun("R10");
    fifoFull = 1'b0;
    hostWrite(7'h10, 32'h0F0F0F0F, 1'b1, 1'b0);
    checkOverrun("R10");

    // R6, R9 16-bit mode
    mode16 = 1'b1;
    hostWrite(7'h33, 32'hABCD1234, 1'b0, 1'b1);
    hostWrite(7'h00, 32'hFFFF5678, 1'b1, 1'b0);
    hostWrite(7'h79, 32'hEEEE9ABC, 1'b1, 1'b1);
    hostWrite(7'h7E, 32'h1111C0DE, 1'b1, 1'b0);
    hostWrite(7'h05, 32'h2222BEEF, 1'b1, 1'b1);
    fifoFull = 1'b1;
    hostWrite(7'h01, 32'h3333DEAD, 1'b1, 1'b0);
    fifoFull = 1'b0;
    checkOverrun("R10");

    // R1 reset clears overrun
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    modelOverrun = 1'b0;
    checkOverrun("R1");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkOverrun("R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule